// File: doc/BRIEF.md
# Command-Word Register Access Bridge

This block lets a host processor reach a slow downstream register space one transaction at a time. The host sees three 32-bit words. It writes a command word that carries a direction flag, a halfword address and write data. It polls a status word that shows the progress of the transaction and returns the read data. It writes a clear word to release a finished read. Behind the bridge is a plain request/acknowledge port. The bridge holds the request until it is acknowledged and captures read data in the same cycle as the acknowledge.

A small state machine tracks each transaction, and its state is visible in the status word. A write returns to idle as soon as the downstream side acknowledges it. A read passes through a one-cycle data stage and then parks in a wait-for-clear state. It stays there until the host writes the clear word, so software always gets to read the data before the next command can start. After reset the bridge runs a fixed-length countdown and then raises an init-done flag. Commands that arrive before that flag is set, or while a transaction is in flight, are dropped and latch a sticky error bit.

Top module: `cmdreg_bridge`

## Requirements
- R1: After reset the status word reads 0x0010_0000 (idle, only the sync-idle bit set) and `dn_req` is low.
- R2: Init-done (status bit 21) rises on exactly the INIT_CYCLES-th clock edge after reset is released and stays set until the next reset.
- R3: An accepted command word drives `dn_wr` from bit 31, `dn_addr` from bits 30:16 and `dn_wdata` from bits 15:0. `dn_req` is high from the cycle after the command write and these outputs hold steady until `dn_ack`.
- R4: A write command shows state 2 (request) and then goes straight back to state 0 (idle) after the acknowledge, without entering state 4 or 6.
- R5: A read command shows state 2, then state 4 (waiting for data) for exactly one cycle, then state 6 (waiting for clear) with the acknowledged data in status bits 15:0.
- R6: Status bits 15:0 read zero in every state other than 6.
- R7: State 6 is left only by a write to the clear word with bit 0 set, which returns the bridge to idle. A write to the clear word with bit 0 clear has no effect.
- R8: A command written while the state is not 0, or before init-done, is ignored: no downstream request starts and the state is unchanged. It also sets a sticky error flag in status bit 23, which only reset clears.
- R9: Status bit fields: 18:16 state, 19 request pending (state 2), 20 sync idle (state not 2), 21 init done, 22 system idle (state 0 with init done), 23 error. All other upper bits read zero.
- R10: The command word is at byte offset BASE (default 0xC20), status at BASE+4 and clear at BASE+8. Reading BASE returns the last accepted command. Writes to any other offset, including the status word, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host access is a write |
| bus_addr | input | 12 | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for the offset on `bus_addr` |
| dn_req | output | 1 | Downstream request |
| dn_wr | output | 1 | Downstream request is a write |
| dn_addr | output | 15 | Downstream halfword address |
| dn_wdata | output | 16 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 16 | Downstream read data, valid with `dn_ack` |

## Verification
The bench targets these corner cases:
- **Command before init-done.** It issues a command in the first cycle after reset and expects no request and a raised error flag. It then checks the init-done edge down to the cycle, where an off-by-one counter would show up.
- **Hold in the wait-for-clear state.** It writes a command and a zero clear word while a read is parked. A design that let either one through would either start a second request or drop the read data before software had it.
- **Read stage sequence.** It checks that the one-cycle data stage appears exactly once and that the data field stays zero outside the final read state, so stale data leaking into the status word would be caught.
- **Random latencies.** Random downstream latencies and address/data patterns, checked against a bench memory image, catch field swaps in command decoding and data captured on the wrong edge.

// File: rtl/cmdreg_bridge_pkg.sv
package cmdreg_bridge_pkg;

  localparam int CMD_W   = 32;
  localparam int DATA_W  = 16;
  localparam int HADDR_W = 15;

  typedef enum logic [2:0] {
    FSM_IDLE      = 3'd0,
    FSM_REQ       = 3'd2,
    FSM_WAIT_DATA = 3'd4,
    FSM_WAIT_CLR  = 3'd6
  } fsm_e;

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] c);
    return c[31];
  endfunction

  function automatic logic [HADDR_W-1:0] cmd_haddr(input logic [CMD_W-1:0] c);
    return c[30:16];
  endfunction

  function automatic logic [DATA_W-1:0] cmd_wdata(input logic [CMD_W-1:0] c);
    return c[DATA_W-1:0];
  endfunction

  function automatic logic [CMD_W-1:0] pack_status(input fsm_e st, input logic init_done,
                                                    input logic err, input logic [DATA_W-1:0] rd);
    logic [CMD_W-1:0] w;
    w        = '0;
    w[15:0]  = (st == FSM_WAIT_CLR) ? rd : '0;
    w[18:16] = st;
    w[19]    = (st == FSM_REQ);
    w[20]    = (st != FSM_REQ);
    w[21]    = init_done;
    w[22]    = (st == FSM_IDLE) && init_done;
    w[23]    = err;
    return w;
  endfunction

endpackage

// File: rtl/brg_init_timer.sv
module brg_init_timer #(
  parameter int INIT_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic init_done
);
  localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES + 1) : 1;

  generate
    if (INIT_CYCLES == 0) begin : g_none
      assign init_done = 1'b1;
    end else begin : g_count
      logic [CNT_W-1:0] cnt;
      logic             done_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt    <= '0;
          done_q <= 1'b0;
        end else if (!done_q) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(INIT_CYCLES - 1)) done_q <= 1'b1;
        end
      end
      assign init_done = done_q;
    end
  endgenerate
endmodule

// File: rtl/brg_host_decode.sv
module brg_host_decode #(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] BASE   = 12'hC20
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              clr_bit,
  output logic              cmd_wr_evt,
  output logic              clr_evt,
  output logic              rd_cmd,
  output logic              rd_stat
);
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(BASE + 12'd4);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(BASE + 12'd8);

  logic wr_strobe;
  assign wr_strobe  = bus_sel && bus_wr;
  assign cmd_wr_evt = wr_strobe && (bus_addr == OFF_CMD);
  assign clr_evt    = wr_strobe && (bus_addr == OFF_CLR) && clr_bit;
  assign rd_cmd     = (bus_addr == OFF_CMD);
  assign rd_stat    = (bus_addr == OFF_STAT);
endmodule

// File: rtl/brg_txn_fsm.sv
module brg_txn_fsm
  import cmdreg_bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_accept,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic               clr_evt,
  input  logic               dn_ack,
  input  logic [DATA_W-1:0]  dn_rdata,
  output fsm_e               state,
  output logic [DATA_W-1:0]  rdata_q,
  output logic               dn_req,
  output logic               dn_wr,
  output logic [HADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0]  dn_wdata
);
  fsm_e state_n;

  always_comb begin
    state_n = state;
    case (state)
      FSM_IDLE:      if (cmd_accept) state_n = FSM_REQ;
      FSM_REQ:       if (dn_ack) state_n = dn_wr ? FSM_IDLE : FSM_WAIT_DATA;
      FSM_WAIT_DATA: state_n = FSM_WAIT_CLR;
      FSM_WAIT_CLR:  if (clr_evt) state_n = FSM_IDLE;
      default:       state_n = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= FSM_IDLE;
      rdata_q  <= '0;
      dn_wr    <= 1'b0;
      dn_addr  <= '0;
      dn_wdata <= '0;
    end else begin
      state <= state_n;
      if (state == FSM_IDLE && cmd_accept) begin
        dn_wr    <= cmd_is_write(cmd_word);
        dn_addr  <= cmd_haddr(cmd_word);
        dn_wdata <= cmd_wdata(cmd_word);
      end
      if (state == FSM_REQ && dn_ack && !dn_wr) rdata_q <= dn_rdata;
    end
  end

  assign dn_req = (state == FSM_REQ);
endmodule

// File: rtl/cmdreg_bridge.sv
module cmdreg_bridge
  import cmdreg_bridge_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] BASE        = 12'hC20,
  parameter int          INIT_CYCLES = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               dn_req,
  output logic               dn_wr,
  output logic [14:0]        dn_addr,
  output logic [15:0]        dn_wdata,
  input  logic               dn_ack,
  input  logic [15:0]        dn_rdata
);
  // named internal events, observed by the bound checker
  logic               init_done;
  logic               cmd_wr_evt;
  logic               clr_evt;
  logic               cmd_accept;
  logic               cmd_reject;
  logic               err_q;
  logic               rd_cmd;
  logic               rd_stat;
  fsm_e               fsm_state;
  logic [DATA_W-1:0]  rdata_q;
  logic [CMD_W-1:0]   cmd_shadow;
  logic [CMD_W-1:0]   status_word;

  brg_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .init_done(init_done)
  );

  brg_host_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .clr_bit(bus_wdata[0]),
    .cmd_wr_evt(cmd_wr_evt), .clr_evt(clr_evt), .rd_cmd(rd_cmd), .rd_stat(rd_stat)
  );

  assign cmd_accept = cmd_wr_evt && init_done && (fsm_state == FSM_IDLE);
  assign cmd_reject = cmd_wr_evt && !cmd_accept;

  brg_txn_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .cmd_word(bus_wdata),
    .clr_evt(clr_evt), .dn_ack(dn_ack), .dn_rdata(dn_rdata),
    .state(fsm_state), .rdata_q(rdata_q),
    .dn_req(dn_req), .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_wdata(dn_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      cmd_shadow <= '0;
    end else begin
      if (cmd_reject) err_q <= 1'b1;
      if (cmd_accept) cmd_shadow <= bus_wdata;
    end
  end

  assign status_word = pack_status(fsm_state, init_done, err_q, rdata_q);

  always_comb begin
    if (rd_cmd)       bus_rdata = cmd_shadow;
    else if (rd_stat) bus_rdata = status_word;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/cmdreg_bridge_chk.sv
module cmdreg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  state,
  input logic        dn_req,
  input logic        dn_ack,
  input logic        dn_wr,
  input logic [14:0] dn_addr,
  input logic [15:0] dn_wdata,
  input logic        clr_evt,
  input logic        cmd_reject,
  input logic        err,
  input logic        init_done,
  input logic [31:0] status_word
);
  a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_wr) && $stable(dn_addr) && $stable(dn_wdata));

  a_r4_write_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack && dn_wr |=> state == 3'd0);

  a_r5_read_to_data: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack && !dn_wr |=> state == 3'd4);

  a_r5_data_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |=> state == 3'd6);

  a_r6_data_masked: assert property (@(posedge clk) disable iff (!rst_n)
    state != 3'd6 |-> status_word[15:0] == 16'h0);

  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd6 && !clr_evt |=> state == 3'd6);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd6 && clr_evt |=> state == 3'd0);

  a_r8_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> err);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r9_state_field: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[18:16] == state && status_word[21] == init_done && status_word[23] == err);
endmodule

bind cmdreg_bridge cmdreg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(fsm_state), .dn_req(dn_req), .dn_ack(dn_ack),
  .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .clr_evt(clr_evt),
  .cmd_reject(cmd_reject), .err(err_q), .init_done(init_done), .status_word(status_word)
);

// File: tb/tb_cmdreg_bridge.sv
module tb_cmdreg_bridge;
  localparam int          CLK_PERIOD = 10;
  localparam int          INIT       = 20;
  localparam logic [11:0] BASE       = 12'hC20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = BASE + 12'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dn_req, dn_wr;
  logic [14:0] dn_addr;
  logic [15:0] dn_wdata;
  logic        dn_ack = 1'b0;
  logic [15:0] dn_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int lat_cfg = 0;
  int lat_cnt = 0;
  logic [15:0] mem     [64];
  logic [15:0] exp_mem [64];
  logic [31:0] last_cmd;
  logic        exp_err;

  cmdreg_bridge #(.ADDR_W(12), .BASE(BASE), .INIT_CYCLES(INIT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dn_req(dn_req), .dn_wr(dn_wr),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // downstream register-file model with programmable latency
  always @(posedge clk) begin
    dn_ack <= 1'b0;
    if (dn_req && !dn_ack) begin
      if (lat_cnt >= lat_cfg) begin
        dn_ack   <= 1'b1;
        lat_cnt  <= 0;
        dn_rdata <= mem[dn_addr[5:0]];
        if (dn_wr) mem[dn_addr[5:0]] <= dn_wdata;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] f_cmd(input logic wr, input logic [14:0] ha, input logic [15:0] d);
    return {wr, ha, d};
  endfunction

  function automatic logic [31:0] f_status(input logic [2:0] st, input logic ini,
                                           input logic er, input logic [15:0] d);
    logic [31:0] w;
    w = {8'h00, er, (st == 3'd0) & ini, ini, st != 3'd2, st == 3'd2, st,
         (st == 3'd6) ? d : 16'h0};
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = BASE + 12'd4; bus_wdata = '0;
    #1;
  endtask

  task automatic read_reg(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
    bus_addr = BASE + 12'd4; #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; exp_err = 1'b0; last_cmd = '0;
    #1;
  endtask

  task automatic wait_init();
    int g = 0;
    while (!bus_rdata[21] && g < 100) begin @(negedge clk); #1; g++; end
  endtask

  task automatic run_txn(input logic wr, input logic [14:0] ha, input logic [15:0] d, input int lat);
    logic [31:0] s;
    int n4 = 0, g = 0;
    bit saw2 = 0, badw = 0, badz = 0;
    lat_cfg = lat;
    host_write(BASE, f_cmd(wr, ha, d));
    last_cmd = f_cmd(wr, ha, d);
    s = bus_rdata;
    while (s[18:16] != (wr ? 3'd0 : 3'd6) && g < 100) begin
      if (s[18:16] == 3'd2) saw2 = 1;
      if (s[18:16] == 3'd4) n4++;
      if (wr && s[18:16] != 3'd2) badw = 1;
      if (s[15:0] != 16'h0) badz = 1;
      @(negedge clk); #1; s = bus_rdata; g++;
    end
    if (wr) begin
      check(saw2 && !badw && g < 100, "R4 write returns to idle", s, f_status(3'd0, 1'b1, exp_err, 16'h0));
      exp_mem[ha[5:0]] = d;
    end else begin
      check(saw2 && n4 == 1, "R5 read stage order", 32'(n4), 32'd1);
      check(s == f_status(3'd6, 1'b1, exp_err, exp_mem[ha[5:0]]), "R5 read data in status",
            s, f_status(3'd6, 1'b1, exp_err, exp_mem[ha[5:0]]));
      check(!badz, "R6 data field zero before state 6", 32'(badz), 32'd0);
      host_write(BASE + 12'd8, 32'h1);
      check(bus_rdata[18:16] == 3'd0, "R7 clear releases read", bus_rdata, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    for (int i = 0; i < 64; i++) begin
      mem[i]     = 16'(i * 16'h1111) ^ 16'hA5A5;
      exp_mem[i] = 16'(i * 16'h1111) ^ 16'hA5A5;
    end
    exp_err = 1'b0; last_cmd = '0;

    // R1 and R2: reset state, early command, init-done timing
    do_reset();
    check(bus_rdata == 32'h0010_0000 && !dn_req, "R1 reset status", bus_rdata, 32'h0010_0000);
    host_write(BASE, f_cmd(1'b1, 15'd3, 16'hBEEF));
    check(!dn_req && bus_rdata[18:16] == 3'd0, "R8 command before init ignored", bus_rdata, 32'h0);
    check(bus_rdata[23] == 1'b1, "R8 early command sets error", bus_rdata, 32'h0080_0000);
    repeat (INIT - 2) @(negedge clk);
    #1;
    check(bus_rdata[21] == 1'b0, "R2 init-done not yet", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check(bus_rdata[21] == 1'b1, "R2 init-done on time", bus_rdata, 32'h0020_0000);

    // second reset clears sticky error
    do_reset();
    check(bus_rdata == 32'h0010_0000, "R1 reset clears error", bus_rdata, 32'h0010_0000);
    wait_init();
    check(bus_rdata == f_status(3'd0, 1'b1, 1'b0, 16'h0), "R9 idle status bits",
          bus_rdata, f_status(3'd0, 1'b1, 1'b0, 16'h0));

    // R3: command field decode and hold
    lat_cfg = 3;
    host_write(BASE, f_cmd(1'b1, 15'd9, 16'h1234));
    last_cmd = f_cmd(1'b1, 15'd9, 16'h1234);
    check(dn_req && dn_wr && dn_addr == 15'd9 && dn_wdata == 16'h1234, "R3 decode",
          {dn_req, dn_wr, dn_addr, dn_wdata[14:0]}, {1'b1, 1'b1, 15'd9, 15'h1234});
    check(bus_rdata == f_status(3'd2, 1'b1, 1'b0, 16'h0), "R9 request status bits",
          bus_rdata, f_status(3'd2, 1'b1, 1'b0, 16'h0));
    @(negedge clk); #1;
    check(dn_req && dn_addr == 15'd9 && dn_wdata == 16'h1234, "R3 request held",
          {16'h0, dn_wdata}, {16'h0, 16'h1234});
    begin
      int g = 0;
      while (bus_rdata[18:16] != 3'd0 && g < 50) begin @(negedge clk); #1; g++; end
    end
    exp_mem[9] = 16'h1234;
    check(bus_rdata[18:16] == 3'd0, "R4 directed write done", bus_rdata, 32'h0);

    // read back, park in state 6, try illegal actions
    lat_cfg = 1;
    host_write(BASE, f_cmd(1'b0, 15'd9, 16'h0));
    last_cmd = f_cmd(1'b0, 15'd9, 16'h0);
    begin
      int g = 0;
      while (bus_rdata[18:16] != 3'd6 && g < 50) begin @(negedge clk); #1; g++; end
    end
    check(bus_rdata == f_status(3'd6, 1'b1, 1'b0, 16'h1234), "R5 directed readback",
          bus_rdata, f_status(3'd6, 1'b1, 1'b0, 16'h1234));
    host_write(BASE + 12'd8, 32'h0000_0002);
    check(bus_rdata[18:16] == 3'd6, "R7 clear with bit0 zero ignored", bus_rdata, 32'h0006_0000);
    host_write(BASE, f_cmd(1'b1, 15'd9, 16'h5555));
    exp_err = 1'b1;
    check(bus_rdata == f_status(3'd6, 1'b1, 1'b1, 16'h1234) && !dn_req, "R8 busy command ignored",
          bus_rdata, f_status(3'd6, 1'b1, 1'b1, 16'h1234));
    host_write(BASE + 12'd4, 32'h0000_0001);
    check(bus_rdata[18:16] == 3'd6, "R10 status write no effect", bus_rdata, 32'h0006_0000);
    host_write(BASE + 12'd8, 32'h1);
    check(bus_rdata == f_status(3'd0, 1'b1, 1'b1, 16'h0), "R7 release and R8 error sticky",
          bus_rdata, f_status(3'd0, 1'b1, 1'b1, 16'h0));

    // R10: other offsets
    host_write(BASE + 12'd12, f_cmd(1'b1, 15'd2, 16'h7777));
    check(bus_rdata[18:16] == 3'd0 && !dn_req, "R10 unmapped write ignored", bus_rdata, 32'h0);
    read_reg(BASE, v);
    check(v == last_cmd, "R10 command readback", v, last_cmd);
    read_reg(BASE + 12'd16, v);
    check(v == 32'h0, "R10 unmapped read zero", v, 32'h0);
    run_txn(1'b0, 15'd2, 16'h0, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic        w;
      logic [14:0] ha;
      logic [15:0] d;
      w  = 1'($urandom % 2);
      ha = 15'($urandom % 64);
      d  = 16'($urandom);
      run_txn(w, ha, d, int'($urandom % 6));
    end
    read_reg(BASE, v);
    check(v == last_cmd, "R10 final command readback", v, last_cmd);
    for (int i = 0; i < 64; i += 9) run_txn(1'b0, 15'(i), 16'h0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule